// File: doc/BRIEF.md
# Cacheability Address Decoder

This block sits between the CPU address path and the cache and memory controllers. For each valid 32-bit CPU address it decides whether the access may be cached, and it produces the 27-bit physical address that the memory controller uses. The physical space is 128 MB, so only the low 27 address bits select a location. Bit 27 is an uncached alias: software sets it to reach any location without caching. The four bits above bit 27 take no part in either result.

Software marks memory as non-cacheable through a small bank of bound registers. Each of two regions has a first page and a last page, both at 4 KB granularity, and an enable flag. The registers are written over a simple write-only port. The decision and the physical address are registered. A result appears one clock after a request is presented, together with a response-valid flag.

Top module: `cache_region_decoder`

## Requirements
- R1: While reset is asserted, and in the cycle after reset ends, rsp_valid, rsp_cacheable and rsp_addr are 0. Reset disables every region, so after reset every address with bit 27 clear is cacheable.
- R2: rsp_valid is 1 in the cycle after a cycle with req_valid high, and 0 in the cycle after a cycle with req_valid low.
- R3: rsp_addr equals bits 26:0 of the req_addr that was accepted one cycle earlier.
- R4: An accepted address with bit 27 set gives rsp_cacheable = 0, whatever the region settings.
- R5: Address bits 31:28 have no effect on rsp_cacheable or rsp_addr.
- R6: An accepted address with bit 27 clear gives rsp_cacheable = 0 exactly when its page (bits 26:12) lies within an enabled region, with both bounds included. Otherwise it gives 1.
- R7: A region whose last page is below its first page matches no address.
- R8: A region whose enable flag is 0 matches no address.
- R9: The bound registers are written when cfg_we is 1. cfg_idx bit 0 selects the word: 0 for the first page, 1 for the last page. cfg_idx bits above bit 0 select the region. cfg_wdata bits 14:0 hold the page number. On a first-page write, cfg_wdata bit 15 is the enable flag. A request that arrives in the same cycle as a write is judged with the settings from before that write.
- R10: While req_valid is low, rsp_cacheable and rsp_addr keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Bound register write strobe |
| cfg_idx | input | 2 | Region (upper bits) and word select (bit 0) |
| cfg_wdata | input | 16 | Page number in bits 14:0; bit 15 is the enable flag on first-page writes |
| req_valid | input | 1 | CPU address is valid this cycle |
| req_addr | input | 32 | CPU address |
| rsp_valid | output | 1 | Registered result is valid |
| rsp_cacheable | output | 1 | 1 when the access may be cached |
| rsp_addr | output | 27 | Physical address for the memory controller |

## Verification
Two events can fall in the same clock cycle: a bound register write and a request whose page lies inside the range that write opens. The bench provokes this by writing the enable flag and first page of a region in the same cycle as it presents a request in that region. It expects the response to use the old, empty range, so the access is cacheable. It then repeats the request alone and expects the new range to apply, so the access is not cacheable. A second overlap is between the alias bit and an address inside an enabled region. There the alias must win.

// File: rtl/crd_pkg.sv
package crd_pkg;

    // Default geometry shared by every module of the decoder
    localparam int DEF_ADDR_W      = 32;   // CPU address width
    localparam int DEF_PHYS_W      = 27;   // 128 MB physical space
    localparam int DEF_PAGE_W      = 12;   // 4 KB region granularity
    localparam int DEF_NUM_REGIONS = 2;    // non-cacheable windows

    // Which bound word of a region a configuration write targets
    typedef enum logic {
        SEL_FIRST = 1'b0,
        SEL_LAST  = 1'b1
    } bound_sel_e;

endpackage

// File: rtl/crd_bounds_regs.sv
module crd_bounds_regs
    import crd_pkg::*;
#(
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    parameter int PAGE_BITS   = DEF_PHYS_W - DEF_PAGE_W,
    parameter int IDX_W       = $clog2(2 * DEF_NUM_REGIONS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [IDX_W-1:0]                 idx_i,
    input  logic [PAGE_BITS:0]               wdata_i,
    output logic [NUM_REGIONS-1:0]           en_o,
    output logic [NUM_REGIONS*PAGE_BITS-1:0] first_o,
    output logic [NUM_REGIONS*PAGE_BITS-1:0] last_o
);

    typedef struct packed {
        logic                 en;
        logic [PAGE_BITS-1:0] first;
        logic [PAGE_BITS-1:0] last;
    } bound_t;

    bound_t [NUM_REGIONS-1:0] tbl_d, tbl_q;

    bound_sel_e word_sel;
    assign word_sel = bound_sel_e'(idx_i[0]);

    always_comb begin
        tbl_d = tbl_q;
        if (we_i) begin
            for (int r = 0; r < NUM_REGIONS; r++) begin
                if (int'(idx_i >> 1) == r) begin
                    if (word_sel == SEL_FIRST) begin
                        tbl_d[r].en    = wdata_i[PAGE_BITS];
                        tbl_d[r].first = wdata_i[PAGE_BITS-1:0];
                    end else begin
                        tbl_d[r].last  = wdata_i[PAGE_BITS-1:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_out
        assign en_o[g]                             = tbl_q[g].en;
        assign first_o[g*PAGE_BITS +: PAGE_BITS]   = tbl_q[g].first;
        assign last_o[g*PAGE_BITS +: PAGE_BITS]    = tbl_q[g].last;
    end

endmodule

// File: rtl/crd_region_match.sv
module crd_region_match #(
    parameter int PAGE_BITS = 15
) (
    input  logic                 en_i,
    input  logic [PAGE_BITS-1:0] first_i,
    input  logic [PAGE_BITS-1:0] last_i,
    input  logic [PAGE_BITS-1:0] page_i,
    output logic                 hit_o
);

    logic above_first;
    logic below_last;

    // Inclusive on both bounds; an inverted pair can never satisfy both
    assign above_first = (page_i >= first_i);
    assign below_last  = (page_i <= last_i);
    assign hit_o       = en_i && above_first && below_last;

endmodule

// File: rtl/crd_classify.sv
module crd_classify
    import crd_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int PHYS_W      = DEF_PHYS_W,
    parameter int PAGE_W      = DEF_PAGE_W,
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    localparam int PAGE_BITS  = PHYS_W - PAGE_W
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic [NUM_REGIONS-1:0] hit_i,
    output logic [PAGE_BITS-1:0]   page_o,
    output logic [PHYS_W-1:0]      phys_o,
    output logic                   cacheable_o
);

    logic alias_uncached;
    logic unused_upper;

    assign page_o         = addr_i[PHYS_W-1:PAGE_W];
    assign phys_o         = addr_i[PHYS_W-1:0];
    assign alias_uncached = addr_i[PHYS_W];
    // Bits above the alias bit take no part in any decision
    assign unused_upper   = ^addr_i[ADDR_W-1:PHYS_W+1];

    assign cacheable_o    = !alias_uncached && !(|hit_i);

endmodule

// File: rtl/cache_region_decoder.sv
module cache_region_decoder
    import crd_pkg::*;
#(
    parameter int ADDR_W      = DEF_ADDR_W,
    parameter int PHYS_W      = DEF_PHYS_W,
    parameter int PAGE_W      = DEF_PAGE_W,
    parameter int NUM_REGIONS = DEF_NUM_REGIONS,
    localparam int PAGE_BITS  = PHYS_W - PAGE_W,
    localparam int CFG_W      = PAGE_BITS + 1,
    localparam int IDX_W      = $clog2(2 * NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_cacheable,
    output logic [PHYS_W-1:0] rsp_addr
);

    logic [NUM_REGIONS-1:0]           reg_en;
    logic [NUM_REGIONS*PAGE_BITS-1:0] reg_first;
    logic [NUM_REGIONS*PAGE_BITS-1:0] reg_last;
    logic [NUM_REGIONS-1:0]           region_hit;
    logic [PAGE_BITS-1:0]             req_page;
    logic [PHYS_W-1:0]                req_phys;
    logic                             req_cacheable;

    crd_bounds_regs #(
        .NUM_REGIONS (NUM_REGIONS),
        .PAGE_BITS   (PAGE_BITS),
        .IDX_W       (IDX_W)
    ) u_bounds (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we),
        .idx_i   (cfg_idx),
        .wdata_i (cfg_wdata),
        .en_o    (reg_en),
        .first_o (reg_first),
        .last_o  (reg_last)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        crd_region_match #(
            .PAGE_BITS (PAGE_BITS)
        ) u_match (
            .en_i    (reg_en[g]),
            .first_i (reg_first[g*PAGE_BITS +: PAGE_BITS]),
            .last_i  (reg_last[g*PAGE_BITS +: PAGE_BITS]),
            .page_i  (req_page),
            .hit_o   (region_hit[g])
        );
    end

    crd_classify #(
        .ADDR_W      (ADDR_W),
        .PHYS_W      (PHYS_W),
        .PAGE_W      (PAGE_W),
        .NUM_REGIONS (NUM_REGIONS)
    ) u_classify (
        .addr_i      (req_addr),
        .hit_i       (region_hit),
        .page_o      (req_page),
        .phys_o      (req_phys),
        .cacheable_o (req_cacheable)
    );

    // Registered response stage
    typedef struct packed {
        logic              vld;
        logic              cacheable;
        logic [PHYS_W-1:0] addr;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    always_comb begin
        rsp_d     = rsp_q;
        rsp_d.vld = req_valid;
        if (req_valid) begin
            rsp_d.cacheable = req_cacheable;
            rsp_d.addr      = req_phys;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid     = rsp_q.vld;
    assign rsp_cacheable = rsp_q.cacheable;
    assign rsp_addr      = rsp_q.addr;

endmodule

// File: rtl/crd_checker.sv
module crd_checker #(
    parameter int ADDR_W = 32,
    parameter int PHYS_W = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic              rsp_cacheable,
    input logic [PHYS_W-1:0] rsp_addr
);

    // R1: reset clears the response stage
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!rsp_valid && !rsp_cacheable && rsp_addr == '0));

    // R2: response valid follows request valid by one cycle
    assert_valid_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R3: physical address is the low bits of the accepted address
    assert_phys_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_addr == $past(req_addr[PHYS_W-1:0])));

    // R4: alias bit always forces an uncached result
    assert_alias_uncached_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr[PHYS_W]) |=> !rsp_cacheable);

    // R10: idle cycles hold the last result
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_cacheable) && $stable(rsp_addr)));

endmodule

bind cache_region_decoder crd_checker #(
    .ADDR_W (ADDR_W),
    .PHYS_W (PHYS_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .rsp_valid     (rsp_valid),
    .rsp_cacheable (rsp_cacheable),
    .rsp_addr      (rsp_addr)
);

// File: tb/cache_region_decoder_test.sv
`timescale 1ns/1ps
module cache_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [1:0]  cfg_idx;
    logic [15:0] cfg_wdata;
    logic        req_valid;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic        rsp_cacheable;
    logic [26:0] rsp_addr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    cache_region_decoder uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_idx       (cfg_idx),
        .cfg_wdata     (cfg_wdata),
        .req_valid     (req_valid),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_cacheable (rsp_cacheable),
        .rsp_addr      (rsp_addr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        cacheable;
    } vec_t;

    // Region 0 enabled over pages 0x010..0x01F; region 1 disabled over 0x100..0x1FF
    localparam vec_t VEC [0:9] = '{
        '{32'h0000_F000, 1'b1},   // R6 page just below region 0
        '{32'h0001_0000, 1'b0},   // R6 first page included
        '{32'h0001_FFFF, 1'b0},   // R6 last page included
        '{32'h0002_0000, 1'b1},   // R6 page just above region 0
        '{32'h0801_0000, 1'b0},   // R4 alias inside region
        '{32'h0800_F000, 1'b0},   // R4 alias outside region
        '{32'hF001_8000, 1'b0},   // R5 upper bits set, inside region
        '{32'hF000_0000, 1'b1},   // R5 upper bits set, outside region
        '{32'h0015_0000, 1'b1},   // R8 inside disabled region 1
        '{32'h07FF_FFFF, 1'b1}    // R6 top of physical space
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] idx, input logic [15:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = idx;
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // Presents one request; on return the response is visible
    task automatic do_req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_idx   = '0;
        cfg_wdata = '0;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rsp_valid == 1'b0, "R1 valid", 32'(rsp_valid), 0);
        check(rsp_cacheable == 1'b0, "R1 cacheable", 32'(rsp_cacheable), 0);
        check(rsp_addr == '0, "R1 addr", 32'(rsp_addr), 0);
        rst_n = 1'b1;

        // R1: everything cacheable before any configuration
        do_req(32'h0001_0000);
        check(rsp_cacheable == 1'b1, "R1 unconfigured", 32'(rsp_cacheable), 1);

        // R9: index bit 0 picks the word, bit 15 of a first-page write enables
        cfg_write(2'd0, {1'b1, 15'h010});
        cfg_write(2'd1, {1'b0, 15'h01F});
        cfg_write(2'd2, {1'b0, 15'h100});
        cfg_write(2'd3, {1'b0, 15'h1FF});

        for (int i = 0; i < 10; i++) begin
            do_req(VEC[i].addr);
            // R2 valid, R3 address, R4/R5/R6/R8 decision
            check(rsp_valid == 1'b1, $sformatf("R2 vector %0d", i), 32'(rsp_valid), 1);
            check(rsp_addr == VEC[i].addr[26:0], $sformatf("R3 vector %0d", i),
                  32'(rsp_addr), 32'(VEC[i].addr[26:0]));
            check(rsp_cacheable == VEC[i].cacheable,
                  $sformatf("R4/R5/R6/R8 vector %0d", i),
                  32'(rsp_cacheable), 32'(VEC[i].cacheable));
        end

        // R7: enable region 1 with first page above last page
        cfg_write(2'd2, {1'b1, 15'h200});
        do_req(32'h0020_0000);
        check(rsp_cacheable == 1'b1, "R7 inverted at first", 32'(rsp_cacheable), 1);
        do_req(32'h001F_F000);
        check(rsp_cacheable == 1'b1, "R7 inverted at last", 32'(rsp_cacheable), 1);

        // R9: write and request in the same cycle use the old bounds
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_idx   = 2'd2;
        cfg_wdata = {1'b1, 15'h100};
        req_valid = 1'b1;
        req_addr  = 32'h0015_0000;
        @(negedge clk);
        cfg_we    = 1'b0;
        req_valid = 1'b0;
        check(rsp_cacheable == 1'b1, "R9 same cycle old bounds", 32'(rsp_cacheable), 1);
        do_req(32'h0015_0000);
        check(rsp_cacheable == 1'b0, "R9 new bounds apply", 32'(rsp_cacheable), 0);

        // R10 and R2: idle cycle drops valid and holds the result
        @(negedge clk);
        check(rsp_valid == 1'b0, "R2 idle valid", 32'(rsp_valid), 0);
        check(rsp_addr == 27'h015_0000, "R10 addr held", 32'(rsp_addr), 32'h0015_0000);
        check(rsp_cacheable == 1'b0, "R10 decision held", 32'(rsp_cacheable), 0);

        // R1: reset mid-run clears outputs and the regions
        rst_n = 1'b0;
        @(negedge clk);
        check(rsp_cacheable == 1'b0 && rsp_addr == '0, "R1 reset mid-run",
              {rsp_cacheable, 4'h0, rsp_addr}, 0);
        rst_n = 1'b1;
        do_req(32'h0015_0000);
        check(rsp_cacheable == 1'b1, "R1 regions cleared", 32'(rsp_cacheable), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule